// File: doc/BRIEF.md
# Dispatch Credit and Serialization Admission

This block sits beside a rename stage and decides, each cycle, how many of the instructions offered to it may go downstream. It keeps its own estimate of the free space in three downstream structures: the reorder buffer (ROB), the issue queue (IQ) and the load/store queue (LSQ). Each estimate is the last free count reported for that structure, minus the instructions the block has admitted that have not yet been dispatched. The tightest of the three bounds the admit count. When admission is cut short, the block raises a block flag and reports which structure was the limit.

The block also sequences serializing instructions. An instruction flagged serialize-before may only go through when the ROB reports empty, nothing is in flight, and nothing ahead of it was admitted in the same cycle. An instruction flagged serialize-after passes that restriction on to the instruction that follows it. If no following instruction is visible yet, the restriction is remembered for the next one. Admission also stops at the first instruction whose destination registers would take more than the free physical register count, counted cumulatively across the slots admitted so far. Slots already marked squashed are skipped.

Offered instructions sit in slots 0 to `availCnt`−1, in program order. Outputs are combinational from the current inputs and the registered state. A report with its valid flag set is captured at the clock edge and takes effect from the next cycle.

Top module: `dcredit_top`

## Requirements
- R1: After reset the stored free counts are zero and the ROB is taken as empty. An offer of one or more instructions before any report then gives admit 0, block 1 and cause 1.
- R2: A free-count report is captured only on a clock edge where its own valid flag is 1. A report with valid 0 leaves the stored value unchanged.
- R3: Free ROB = stored ROB count − (in-flight − `dispTotal`), and free IQ uses the same formula with the IQ count. Free LSQ = stored LSQ count − (in-flight − `dispLsq`).
- R4: The credit is the smallest of the three free values. The cause code is 1 for ROB, 2 for IQ and 3 for LSQ. On equal values the lower code wins.
- R5: With at least one instruction offered and a credit of 0 or less, admit is 0, block is 1 and the cause code names the limiting structure.
- R6: When more non-squashed instructions are offered than the credit allows, exactly the credit is admitted, block is 1 and the cause is reported.
- R7: The in-flight count grows by the admit count at each edge and shrinks by `dispTotal`.
- R8: A squashed slot is skipped. It is neither admitted nor charged against the credit or the register count.
- R9: Admission stops before the first slot whose destination count would push the running total of destination registers above `freePhysRegs`. Block is then 1 and the cause is 0.
- R10: A serialize-before slot is admitted only if the ROB is empty, in-flight is zero and no earlier slot was admitted this cycle. Otherwise admission stops there with block 1 and cause 0.
- R11: A serialize-after slot makes the next non-squashed slot behave as serialize-before. If the cycle ends before such a slot, a pending flag carries the mark to the next cycle. That flag is dropped with no effect once the ROB is empty and in-flight is zero.
- R12: With no instructions offered, admit is 0, block is 0 and cause is 0. Admit never exceeds `availCnt` or WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| robFreeVld | input | 1 | ROB report valid |
| robFreeCnt | input | CNT_W | Reported ROB free entries |
| robEmptyIn | input | 1 | ROB-empty flag carried with the ROB report |
| iqFreeVld | input | 1 | IQ report valid |
| iqFreeCnt | input | CNT_W | Reported IQ free entries |
| lsqFreeVld | input | 1 | LSQ report valid |
| lsqFreeCnt | input | CNT_W | Reported LSQ free entries |
| dispTotal | input | CNT_W | Instructions dispatched downstream this cycle |
| dispLsq | input | CNT_W | Of those, instructions dispatched to the LSQ |
| availCnt | input | ADM_W | Instructions offered this cycle (slots 0..availCnt−1) |
| slotSquash | input | WIDTH | Per-slot squashed flag |
| slotSerBefore | input | WIDTH | Per-slot serialize-before flag |
| slotSerAfter | input | WIDTH | Per-slot serialize-after flag |
| slotDest | input | WIDTH*DEST_W | Per-slot destination register count, slot i at bits [i*DEST_W +: DEST_W] |
| freePhysRegs | input | PREG_W | Free physical registers |
| admitCnt | output | ADM_W | Instructions admitted this cycle |
| blockOut | output | 1 | Admission stopped short this cycle |
| fullCause | output | 2 | 0 none, 1 ROB, 2 IQ, 3 LSQ |

## Verification
The assertions rely on the surrounding pipeline never dispatching more than is in flight. They also rely on `dispLsq` never exceeding `dispTotal` and on `availCnt` never exceeding WIDTH. The stimulus respects these by zeroing the offer on every edge where admission is not meant to commit. It dispatches only counts that match what the bench knows it admitted earlier. The serialization checks depend on the bench presenting a stalled instruction again in slot 0 on the next cycle, which each scenario does.

// File: rtl/dcredit_pkg.sv
package dcredit_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_ROB  = 2'd1,
    CAUSE_IQ   = 2'd2,
    CAUSE_LSQ  = 2'd3
  } fullCause_e;

  localparam int STROBE_W = 8;

  // Control -> datapath: what was admitted this cycle.
  typedef struct packed {
    logic                take;
    logic [STROBE_W-1:0] takeCnt;
  } admitStrobe_t;
endpackage

// File: rtl/dcredit_dp.sv
module dcredit_dp
  import dcredit_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int FLIGHT_W = 8,
  parameter int FW       = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 robFreeVld,
  input  logic [CNT_W-1:0]     robFreeCnt,
  input  logic                 robEmptyIn,
  input  logic                 iqFreeVld,
  input  logic [CNT_W-1:0]     iqFreeCnt,
  input  logic                 lsqFreeVld,
  input  logic [CNT_W-1:0]     lsqFreeCnt,
  input  logic [CNT_W-1:0]     dispTotal,
  input  logic [CNT_W-1:0]     dispLsq,
  input  admitStrobe_t         strobe,
  output logic signed [FW-1:0] credit,
  output fullCause_e           creditCause,
  output logic                 serReady
);
  localparam int NSTRUCT = 3;

  logic [NSTRUCT-1:0] rptVld;
  logic [CNT_W-1:0]   rptIn   [NSTRUCT];
  logic [CNT_W-1:0]   rptHeld [NSTRUCT];
  logic signed [FW-1:0] freeEst [NSTRUCT];
  logic [FLIGHT_W-1:0]  inFlight;
  logic                 robEmptyHeld;

  assign rptVld = {lsqFreeVld, iqFreeVld, robFreeVld};
  assign rptIn[0] = robFreeCnt;
  assign rptIn[1] = iqFreeCnt;
  assign rptIn[2] = lsqFreeCnt;

  for (genvar k = 0; k < NSTRUCT; k++) begin : g_struct
    logic [CNT_W-1:0] leaving;
    if (k == NSTRUCT - 1) begin : g_lsq
      assign leaving = dispLsq;
    end else begin : g_other
      assign leaving = dispTotal;
    end

    always_ff @(posedge clk) begin
      if (!rstN)          rptHeld[k] <= '0;
      else if (rptVld[k]) rptHeld[k] <= rptIn[k];
    end

    assign freeEst[k] = $signed(FW'(rptHeld[k]))
                      - ($signed(FW'(inFlight)) - $signed(FW'(leaving)));
  end

  always_ff @(posedge clk) begin
    if (!rstN)           robEmptyHeld <= 1'b1;
    else if (robFreeVld) robEmptyHeld <= robEmptyIn;
  end

  // In-flight bookkeeping, floored at zero.
  logic [FLIGHT_W:0] grown;
  logic [FLIGHT_W:0] leaveAll;
  assign grown    = (FLIGHT_W+1)'(inFlight)
                  + (strobe.take ? (FLIGHT_W+1)'(strobe.takeCnt) : '0);
  assign leaveAll = (FLIGHT_W+1)'(dispTotal);

  always_ff @(posedge clk) begin
    if (!rstN)                  inFlight <= '0;
    else if (grown < leaveAll)  inFlight <= '0;
    else                        inFlight <= FLIGHT_W'(grown - leaveAll);
  end

  // Minimum with ROB > IQ > LSQ priority on ties (strict compare).
  always_comb begin
    credit      = freeEst[0];
    creditCause = CAUSE_ROB;
    if (freeEst[1] < credit) begin
      credit      = freeEst[1];
      creditCause = CAUSE_IQ;
    end
    if (freeEst[2] < credit) begin
      credit      = freeEst[2];
      creditCause = CAUSE_LSQ;
    end
  end

  assign serReady = robEmptyHeld && (inFlight == '0);
endmodule

// File: rtl/dcredit_ctrl.sv
module dcredit_ctrl
  import dcredit_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int ADM_W  = 3,
  parameter int DEST_W = 2,
  parameter int PREG_W = 8,
  parameter int FW     = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADM_W-1:0]        availCnt,
  input  logic [WIDTH-1:0]        slotSquash,
  input  logic [WIDTH-1:0]        slotSerBefore,
  input  logic [WIDTH-1:0]        slotSerAfter,
  input  logic [WIDTH*DEST_W-1:0] slotDest,
  input  logic [PREG_W-1:0]       freePhysRegs,
  input  logic signed [FW-1:0]    credit,
  input  fullCause_e              creditCause,
  input  logic                    serReady,
  output logic [ADM_W-1:0]        admitCnt,
  output logic                    blockOut,
  output logic [1:0]              fullCause,
  output admitStrobe_t            strobe
);
  logic pendSer;
  logic pendSerNext;

  always_comb begin
    int  taken;
    int  regsUsed;
    int  creditInt;
    logic stopped;
    logic markNext;

    taken     = 0;
    regsUsed  = 0;
    creditInt = int'(credit);
    stopped   = 1'b0;
    markNext  = pendSer && !serReady;
    blockOut  = 1'b0;
    fullCause = CAUSE_NONE;

    if (availCnt != '0) begin
      if (creditInt <= 0) begin
        blockOut  = 1'b1;
        fullCause = creditCause;
      end else begin
        for (int i = 0; i < WIDTH; i++) begin
          if (!stopped && (i < int'(availCnt)) && !slotSquash[i]) begin
            if (taken >= creditInt) begin
              stopped   = 1'b1;
              blockOut  = 1'b1;
              fullCause = creditCause;
            end else if ((slotSerBefore[i] || markNext)
                         && !(serReady && taken == 0)) begin
              stopped  = 1'b1;
              blockOut = 1'b1;
            end else if (regsUsed + int'(slotDest[i*DEST_W +: DEST_W])
                         > int'(freePhysRegs)) begin
              stopped  = 1'b1;
              blockOut = 1'b1;
            end else begin
              taken    = taken + 1;
              regsUsed = regsUsed + int'(slotDest[i*DEST_W +: DEST_W]);
              markNext = slotSerAfter[i];
            end
          end
        end
      end
    end

    pendSerNext    = markNext;
    admitCnt       = ADM_W'(taken);
    strobe.take    = (taken != 0);
    strobe.takeCnt = STROBE_W'(taken);
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendSer <= 1'b0;
    else       pendSer <= pendSerNext;
  end
endmodule

// File: rtl/dcredit_top.sv
module dcredit_top
  import dcredit_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int CNT_W    = 8,
  parameter int FLIGHT_W = 8,
  parameter int DEST_W   = 2,
  parameter int PREG_W   = 8,
  localparam int ADM_W   = $clog2(WIDTH + 1),
  localparam int FW      = ((CNT_W > FLIGHT_W) ? CNT_W : FLIGHT_W) + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    robFreeVld,
  input  logic [CNT_W-1:0]        robFreeCnt,
  input  logic                    robEmptyIn,
  input  logic                    iqFreeVld,
  input  logic [CNT_W-1:0]        iqFreeCnt,
  input  logic                    lsqFreeVld,
  input  logic [CNT_W-1:0]        lsqFreeCnt,
  input  logic [CNT_W-1:0]        dispTotal,
  input  logic [CNT_W-1:0]        dispLsq,
  input  logic [ADM_W-1:0]        availCnt,
  input  logic [WIDTH-1:0]        slotSquash,
  input  logic [WIDTH-1:0]        slotSerBefore,
  input  logic [WIDTH-1:0]        slotSerAfter,
  input  logic [WIDTH*DEST_W-1:0] slotDest,
  input  logic [PREG_W-1:0]       freePhysRegs,
  output logic [ADM_W-1:0]        admitCnt,
  output logic                    blockOut,
  output logic [1:0]              fullCause
);
  logic signed [FW-1:0] credit;
  fullCause_e           creditCause;
  logic                 serReady;
  admitStrobe_t         strobe;

  dcredit_dp #(.CNT_W(CNT_W), .FLIGHT_W(FLIGHT_W), .FW(FW)) i_dp (
    .clk, .rstN,
    .robFreeVld, .robFreeCnt, .robEmptyIn,
    .iqFreeVld, .iqFreeCnt,
    .lsqFreeVld, .lsqFreeCnt,
    .dispTotal, .dispLsq,
    .strobe, .credit, .creditCause, .serReady
  );

  dcredit_ctrl #(.WIDTH(WIDTH), .ADM_W(ADM_W), .DEST_W(DEST_W),
                 .PREG_W(PREG_W), .FW(FW)) i_ctrl (
    .clk, .rstN,
    .availCnt, .slotSquash, .slotSerBefore, .slotSerAfter, .slotDest,
    .freePhysRegs, .credit, .creditCause, .serReady,
    .admitCnt, .blockOut, .fullCause, .strobe
  );
endmodule

// File: rtl/dcredit_chk.sv
module dcredit_chk #(
  parameter int WIDTH = 4,
  parameter int CNT_W = 8,
  parameter int ADM_W = 3,
  parameter int FW    = 10
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 robFreeVld,
  input logic                 iqFreeVld,
  input logic                 lsqFreeVld,
  input logic [CNT_W-1:0]     dispTotal,
  input logic [CNT_W-1:0]     dispLsq,
  input logic [ADM_W-1:0]     availCnt,
  input logic [WIDTH-1:0]     slotSquash,
  input logic [WIDTH-1:0]     slotSerBefore,
  input logic signed [FW-1:0] credit,
  input logic                 serReady,
  input logic [ADM_W-1:0]     admitCnt,
  input logic                 blockOut,
  input logic [1:0]           fullCause
);
  // R12: admit bounded by offer and width
  a_r12_admit_bound: assert property (@(posedge clk) disable iff (!rstN)
    (int'(admitCnt) <= WIDTH) && (admitCnt <= availCnt));

  // R5: no credit means nothing admitted and a named cause
  a_r5_no_credit: assert property (@(posedge clk) disable iff (!rstN)
    (availCnt != '0 && credit <= 0) |-> (admitCnt == '0 && blockOut && fullCause != 2'd0));

  // R6: admission never exceeds positive credit
  a_r6_within_credit: assert property (@(posedge clk) disable iff (!rstN)
    (credit > 0) |-> (int'(admitCnt) <= int'(credit)));

  // R10: serialize-before at the head holds while not drained
  a_r10_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    (availCnt != '0 && !slotSquash[0] && slotSerBefore[0] && !serReady)
      |-> (admitCnt == '0 && blockOut));

  // R7: with nothing admitted, dispatched or reported, credit stays put
  a_r7_quiet_stable: assert property (@(posedge clk) disable iff (!rstN)
    ($past(admitCnt == '0 && dispTotal == '0 && dispLsq == '0
           && !robFreeVld && !iqFreeVld && !lsqFreeVld)
     && dispTotal == '0 && dispLsq == '0) |-> (credit == $past(credit)));

  // R3: LSQ dispatches are a subset of all dispatches (input assumption)
  a_r3_lsq_subset: assert property (@(posedge clk) disable iff (!rstN)
    dispLsq <= dispTotal);
endmodule

bind dcredit_top dcredit_chk #(
  .WIDTH(WIDTH), .CNT_W(CNT_W), .ADM_W(ADM_W), .FW(FW)
) u_chk (
  .clk(clk), .rstN(rstN),
  .robFreeVld(robFreeVld), .iqFreeVld(iqFreeVld), .lsqFreeVld(lsqFreeVld),
  .dispTotal(dispTotal), .dispLsq(dispLsq),
  .availCnt(availCnt), .slotSquash(slotSquash), .slotSerBefore(slotSerBefore),
  .credit(credit), .serReady(serReady),
  .admitCnt(admitCnt), .blockOut(blockOut), .fullCause(fullCause)
);

// File: tb/test_dcredit_top.sv
module test_dcredit_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH  = 4;
  localparam int CNT_W  = 8;
  localparam int DEST_W = 2;
  localparam int PREG_W = 8;
  localparam int ADM_W  = $clog2(WIDTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic robFreeVld, iqFreeVld, lsqFreeVld, robEmptyIn;
  logic [CNT_W-1:0] robFreeCnt, iqFreeCnt, lsqFreeCnt, dispTotal, dispLsq;
  logic [ADM_W-1:0] availCnt;
  logic [WIDTH-1:0] slotSquash, slotSerBefore, slotSerAfter;
  logic [WIDTH*DEST_W-1:0] slotDest;
  logic [PREG_W-1:0] freePhysRegs;
  logic [ADM_W-1:0] admitCnt;
  logic blockOut;
  logic [1:0] fullCause;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcredit_top #(.WIDTH(WIDTH), .CNT_W(CNT_W), .DEST_W(DEST_W), .PREG_W(PREG_W))
  i_dcredit_top (.*);

  task automatic clearIn();
    robFreeVld = 0; iqFreeVld = 0; lsqFreeVld = 0; robEmptyIn = 1;
    robFreeCnt = '0; iqFreeCnt = '0; lsqFreeCnt = '0;
    dispTotal = '0; dispLsq = '0; availCnt = '0;
    slotSquash = '0; slotSerBefore = '0; slotSerAfter = '0;
    slotDest = '0; freePhysRegs = '1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, int expAdm, bit expBlk, int expCause);
    #1;
    nChecks++;
    if (int'(admitCnt) != expAdm || blockOut != expBlk || int'(fullCause) != expCause) begin
      nFails++;
      $display("FAIL %s: admit/block/cause got %0d/%0d/%0d expected %0d/%0d/%0d",
               req, admitCnt, blockOut, fullCause, expAdm, expBlk, expCause);
    end
  endtask

  task automatic setRpt(int rob, int iq, int lsq, bit emp);
    clearIn();
    robFreeVld = 1; iqFreeVld = 1; lsqFreeVld = 1;
    robFreeCnt = CNT_W'(rob); iqFreeCnt = CNT_W'(iq); lsqFreeCnt = CNT_W'(lsq);
    robEmptyIn = emp;
    tick();
    clearIn();
  endtask

  task automatic testReset();
    check("R12 idle after reset", 0, 0, 0);
    availCnt = 2;
    check("R1 no report yet", 0, 1, 1);
    clearIn();
  endtask

  task automatic testFormula();   // inFlight 0 -> 4
    setRpt(10, 10, 10, 1);
    availCnt = 4;
    check("R3 full credit", 4, 0, 0);
    tick();
    clearIn();
  endtask

  task automatic testValid();     // only ROB report taken
    robFreeVld = 1; robFreeCnt = 7;
    iqFreeVld = 0;  iqFreeCnt = 0;
    lsqFreeVld = 0; lsqFreeCnt = 0;
    tick();
    clearIn();
    availCnt = 4;
    check("R2 invalid report ignored", 3, 1, 1);
    dispTotal = 2;
    check("R3 dispatched returns credit", 4, 0, 0);
    clearIn();
  endtask

  task automatic testLsq();       // inFlight 4
    setRpt(20, 20, 5, 1);
    availCnt = 3;
    check("R4 LSQ limits", 1, 1, 3);
    dispTotal = 3; dispLsq = 0;
    check("R3 LSQ ignores non-LSQ dispatch", 1, 1, 3);
    dispLsq = 3;
    check("R3 LSQ uses LSQ dispatch", 3, 0, 0);
    clearIn();
  endtask

  task automatic testTie();       // inFlight 4
    setRpt(6, 6, 7, 1);
    availCnt = 3;
    check("R4 ROB wins tie", 2, 1, 1);
    setRpt(7, 6, 6, 1);
    availCnt = 3;
    check("R4 IQ wins tie over LSQ", 2, 1, 2);
    setRpt(9, 9, 5, 1);
    availCnt = 3;
    check("R6 capped by LSQ", 1, 1, 3);
    clearIn();
  endtask

  task automatic testFlight();    // inFlight 4 -> 0 -> 2 -> 0
    dispTotal = 4;
    tick();
    clearIn();
    setRpt(2, 9, 9, 1);
    availCnt = 3;
    check("R7 drained in-flight", 2, 1, 1);
    availCnt = 2;
    check("R6 exact fit", 2, 0, 0);
    tick();
    clearIn();
    availCnt = 1;
    check("R7 admitted counted R5", 0, 1, 1);
    clearIn();
    dispTotal = 2;
    tick();
    clearIn();
  endtask

  task automatic testSquash();    // inFlight 0
    setRpt(2, 50, 50, 1);
    availCnt = 4; slotSquash = 4'b1010;
    check("R8 squashed slots cost nothing", 2, 0, 0);
    availCnt = 3; slotSquash = 4'b0001;
    check("R8 squashed head skipped", 2, 0, 0);
    clearIn();
  endtask

  task automatic testRegs();
    setRpt(50, 50, 50, 1);
    availCnt = 4; freePhysRegs = 3;
    slotDest = {2'd0, 2'd2, 2'd1, 2'd1};
    check("R9 register shortage", 2, 1, 0);
    freePhysRegs = 4;
    check("R9 registers exactly enough", 4, 0, 0);
    clearIn();
  endtask

  task automatic testSerBefore(); // inFlight 0
    availCnt = 3; slotSerBefore = 4'b0001;
    check("R10 head passes when drained", 3, 0, 0);
    slotSerBefore = 4'b0010;
    check("R10 stops behind admitted slot", 1, 1, 0);
    tick();                       // inFlight 1
    clearIn();
    availCnt = 2; slotSerBefore = 4'b0001;
    check("R10 waits for in-flight", 0, 1, 0);
    clearIn();
    dispTotal = 1;
    tick();                       // inFlight 0
    clearIn();
    setRpt(50, 50, 50, 0);
    availCnt = 2; slotSerBefore = 4'b0001;
    check("R10 waits for ROB empty", 0, 1, 0);
    setRpt(50, 50, 50, 1);
    availCnt = 2; slotSerBefore = 4'b0001;
    check("R10 released", 2, 0, 0);
    clearIn();
  endtask

  task automatic testSerAfter();  // inFlight 0
    availCnt = 2; slotSerAfter = 4'b0001;
    check("R11 marks following slot", 1, 1, 0);
    availCnt = 1;
    check("R11 last slot admitted", 1, 0, 0);
    tick();                       // inFlight 1, pending set
    clearIn();
    availCnt = 1;
    check("R11 pending mark holds", 0, 1, 0);
    clearIn();
    dispTotal = 1;
    tick();                       // inFlight 0, pending kept
    clearIn();
    tick();                       // pending dropped
    availCnt = 1;
    check("R11 pending dropped", 1, 0, 0);
    tick();                       // inFlight 1
    clearIn();
    availCnt = 1;
    check("R11 no leftover mark", 1, 0, 0);
    clearIn();
    dispTotal = 1;
    tick();
    clearIn();
  endtask

  initial begin
    clearIn();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFormula();
    testValid();
    testLsq();
    testTie();
    testFlight();
    testSquash();
    testRegs();
    testSerBefore();
    testSerAfter();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule